// File: doc/BRIEF.md
# SMBus Target Front End for a Temperature Monitor

This block is the serial face of a temperature-monitor register file. It takes SCL and SDA from open-drain pads and cleans them up. It frames start, repeated start and stop conditions and responds only to its own hard-wired 7-bit address. The decoded traffic is turned into single-cycle strobes for the register file around it. A command pointer survives from one transaction to the next, so the host can poll a register with a plain address-plus-read transfer after it has set the pointer once.

On writes, registers that are read at one command code and written at another are folded onto a single register index. A dedicated command code triggers a one-shot conversion and stores nothing. A read of the status location raises a strobe so the alert logic can react.

The block also takes part in alert-response arbitration. It gives up on the first bit it loses, and after a clean send of its address it pulses a signal that tells the alert logic to release the line and set its mask. If either bus line stays low too long, the block returns to idle. The block never drives SCL and never stretches the clock.

Top module: `smb_target`

## Requirements
- R1: Only the address byte 0x98 (write) or 0x99 (read), which is target address 1001100, is acknowledged. Any other address is left unacknowledged, apart from the alert-response case in R8.
- R2: The command pointer is 00h after reset and keeps its value between transactions. An address-only read (byte 0x99) returns `regRdData` for `regRdAddr` equal to the pointer.
- R3: A write accepts the address byte, the command byte and exactly one data byte, and gives exactly one single-cycle strobe. Any further data byte is not acknowledged and gives no strobe. A write that carries only the command byte sets the pointer and gives no strobe.
- R4: A write command from 09h to 0Eh gives `regWrEn` with `regWrAddr` equal to the command minus 6 (read index 03h to 08h). A write command from 00h to 08h gives no strobe. A write command of 10h or above passes through unchanged.
- R5: A write to command 0Fh gives one `oneShot` pulse and no `regWrEn`. A read with the pointer at 0Fh returns 00h.
- R6: A read that uses a repeated start after the command byte returns the selected register, MSB first. If the host acknowledges, the same register is sent again. If the host does not acknowledge, the block stops driving SDA.
- R7: Each byte loaded for sending while the pointer is 02h gives one `statusRd` pulse, whether or not the host later acknowledges it.
- R8: The read address byte 0x19 (address 0001100) is acknowledged only while `alertActive` is 1 and `alertCfg` is 0. The block then sends 0x98 and pulses `araDone` once, after the eighth bit.
- R9: If SDA is low at a bit where the block sends a 1 during the alert-response send, the block stops driving for the rest of the transfer and gives no `araDone`.
- R10: If SCL or SDA stays low for TIMEOUT clock cycles in a row, the block goes idle and releases SDA.
- R11: A start condition seen in any state, including partway through an address byte, restarts address reception.
- R12: The SDA drive changes only while the filtered SCL is low. The one exception is the release on timeout.
- R13: After reset, `sdaOe`, `regWrEn`, `oneShot`, `statusRd` and `araDone` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level from the pad |
| sdaIn | input | 1 | SDA level from the pad |
| sdaOe | output | 1 | 1 pulls SDA low |
| alertActive | input | 1 | The alert logic is currently asserting its alert |
| alertCfg | input | 1 | Alert-configure bit; 0 enables alert-response answers |
| araDone | output | 1 | Pulse: own address sent; release the alert and set the mask |
| regRdAddr | output | 8 | Register index being read (the command pointer) |
| regRdData | input | 8 | Read data for `regRdAddr` |
| regWrEn | output | 1 | Single-cycle register write strobe |
| regWrAddr | output | 8 | Register index of the write, after folding |
| regWrData | output | 8 | Data of the write |
| oneShot | output | 1 | Pulse: one-shot conversion requested |
| statusRd | output | 1 | Pulse: status byte loaded for sending |

## Verification
Two situations are hard to reach from the ports. The first is a timeout that occurs while the block itself holds SDA low in the middle of a read byte. To get there, the bench sets the pointer to a register whose top bit is 0, so the block is driving when the host freezes SCL low. The bench then watches for the release and checks that a normal transfer still works afterwards. The second is a lost alert-response arbitration. The bench models a second open-drain device that pulls SDA low during the first bit of the block's reply. It then confirms that every later bit reads back high and that no `araDone` pulse appears.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX_ADDR, ST_RX_CMD, ST_RX_DATA,
    ST_ACK_ADDR, ST_ACK_CMD, ST_ACK_DATA,
    ST_TX, ST_HOST_ACK, ST_WAIT
  } busState_t;

  typedef struct packed {
    logic shiftIn;   // sample SDA into the shifter
    logic shiftOut;  // advance the transmit shifter
    logic loadReg;   // load register read data for sending
    logic loadAra;   // load own address for alert response
    logic setPtr;    // latch received byte as command pointer
    logic doWrite;   // issue write for received data byte
  } dpCtl_t;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lvl,
  output logic rise,
  output logic fall
);
  localparam int CNT_W = $clog2(FILT + 1);

  logic s0, s1;
  logic [CNT_W-1:0] stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s0 <= 1'b1;
      s1 <= 1'b1;
      lvl <= 1'b1;
      rise <= 1'b0;
      fall <= 1'b0;
      stableCnt <= '0;
    end else begin
      s0 <= rawIn;
      s1 <= s0;
      rise <= 1'b0;
      fall <= 1'b0;
      if (s1 == lvl) begin
        stableCnt <= '0;
      end else if (stableCnt == CNT_W'(FILT - 1)) begin
        lvl <= s1;
        rise <= s1;
        fall <= !s1;
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h4C,
  parameter logic [6:0] ARA_ADDR = 7'h0C,
  parameter int TIMEOUT = 8750000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclLvl,
  input  logic sclRise,
  input  logic sclFall,
  input  logic sdaLvl,
  input  logic sdaRise,
  input  logic sdaFall,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic txBit,
  input  logic alertActive,
  input  logic alertCfg,
  output dpCtl_t ctl,
  output logic sdaOe,
  output logic araDone,
  output logic timedOut
);
  localparam int TMR_W = $clog2(TIMEOUT + 1);

  busState_t state, nxt;
  logic [3:0] bitCnt, cntNxt;
  logic araMode, araNxt, rdMode, rdNxt, hostAck, ackNxt, doneNxt;
  logic [TMR_W-1:0] sclLowCnt, sdaLowCnt;
  logic startDet, stopDet;

  assign startDet = sdaFall && sclLvl;
  assign stopDet  = sdaRise && sclLvl;
  assign timedOut = (sclLowCnt == TMR_W'(TIMEOUT)) || (sdaLowCnt == TMR_W'(TIMEOUT));

  always_comb begin
    ctl = '0;
    nxt = state;
    cntNxt = bitCnt;
    araNxt = araMode;
    rdNxt = rdMode;
    ackNxt = hostAck;
    doneNxt = 1'b0;
    if (timedOut) begin
      nxt = ST_IDLE;
    end else if (startDet) begin
      nxt = ST_RX_ADDR;
      cntNxt = '0;
      araNxt = 1'b0;
    end else if (stopDet) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_RX_ADDR, ST_RX_CMD, ST_RX_DATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            ctl.shiftIn = 1'b1;
            cntNxt = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_RX_ADDR) begin
              if (rxByte[7:1] == OWN_ADDR) begin
                nxt = ST_ACK_ADDR;
                rdNxt = rxByte[0];
              end else if (rxByte == {ARA_ADDR, 1'b1} && alertActive && !alertCfg) begin
                nxt = ST_ACK_ADDR;
                araNxt = 1'b1;
              end else begin
                nxt = ST_WAIT;
              end
            end else if (state == ST_RX_CMD) begin
              nxt = ST_ACK_CMD;
              ctl.setPtr = 1'b1;
            end else begin
              nxt = ST_ACK_DATA;
              ctl.doWrite = 1'b1;
            end
          end
        end
        ST_ACK_ADDR: if (sclFall) begin
          cntNxt = '0;
          if (araMode) begin
            nxt = ST_TX;
            ctl.loadAra = 1'b1;
          end else if (rdMode) begin
            nxt = ST_TX;
            ctl.loadReg = 1'b1;
          end else begin
            nxt = ST_RX_CMD;
          end
        end
        ST_ACK_CMD: if (sclFall) begin
          nxt = ST_RX_DATA;
          cntNxt = '0;
        end
        ST_ACK_DATA: if (sclFall) nxt = ST_WAIT;
        ST_TX: begin
          if (sclRise && araMode && txBit && !sdaLvl) begin
            nxt = ST_WAIT;
          end else if (sclFall) begin
            if (bitCnt == 4'd7) begin
              nxt = ST_HOST_ACK;
              doneNxt = araMode;
            end else begin
              ctl.shiftOut = 1'b1;
              cntNxt = bitCnt + 1'b1;
            end
          end
        end
        ST_HOST_ACK: begin
          if (sclRise) ackNxt = !sdaLvl;
          if (sclFall) begin
            if (!araMode && hostAck) begin
              nxt = ST_TX;
              cntNxt = '0;
              ctl.loadReg = 1'b1;
            end else begin
              nxt = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      araMode <= 1'b0;
      rdMode <= 1'b0;
      hostAck <= 1'b0;
      araDone <= 1'b0;
      sclLowCnt <= '0;
      sdaLowCnt <= '0;
    end else begin
      state <= nxt;
      bitCnt <= cntNxt;
      araMode <= araNxt;
      rdMode <= rdNxt;
      hostAck <= ackNxt;
      araDone <= doneNxt;
      if (sclLvl) sclLowCnt <= '0;
      else if (sclLowCnt != TMR_W'(TIMEOUT)) sclLowCnt <= sclLowCnt + 1'b1;
      if (sdaLvl) sdaLowCnt <= '0;
      else if (sdaLowCnt != TMR_W'(TIMEOUT)) sdaLowCnt <= sdaLowCnt + 1'b1;
    end
  end

  assign sdaOe = (state == ST_ACK_ADDR) || (state == ST_ACK_CMD) ||
                 (state == ST_ACK_DATA) || (state == ST_TX && !txBit);
endmodule

// File: rtl/smb_dp.sv
module smb_dp
  import smb_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h4C,
  parameter logic [BYTE_W-1:0] STATUS_CMD = 8'h02,
  parameter logic [BYTE_W-1:0] ONESHOT_CMD = 8'h0F,
  parameter logic [BYTE_W-1:0] RO_LAST = 8'h08,
  parameter logic [BYTE_W-1:0] ALIAS_FIRST = 8'h09,
  parameter logic [BYTE_W-1:0] ALIAS_LAST = 8'h0E,
  parameter logic [BYTE_W-1:0] ALIAS_SHIFT = 8'h06
) (
  input  logic clk,
  input  logic rstN,
  input  dpCtl_t ctl,
  input  logic sdaLvl,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic txBit,
  output logic [BYTE_W-1:0] regRdAddr,
  output logic regWrEn,
  output logic [BYTE_W-1:0] regWrAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic oneShot,
  output logic statusRd
);
  logic [BYTE_W-1:0] shifter, cmdPtr;

  assign rxByte = shifter;
  assign txBit = shifter[BYTE_W-1];
  assign regRdAddr = cmdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shifter <= '0;
      cmdPtr <= '0;
      regWrEn <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
      oneShot <= 1'b0;
      statusRd <= 1'b0;
    end else begin
      regWrEn <= 1'b0;
      oneShot <= 1'b0;
      statusRd <= 1'b0;
      if (ctl.shiftIn) shifter <= {shifter[BYTE_W-2:0], sdaLvl};
      if (ctl.shiftOut) shifter <= {shifter[BYTE_W-2:0], 1'b1};
      if (ctl.loadAra) shifter <= {OWN_ADDR, 1'b0};
      if (ctl.loadReg) begin
        shifter <= (cmdPtr == ONESHOT_CMD) ? '0 : regRdData;
        statusRd <= (cmdPtr == STATUS_CMD);
      end
      if (ctl.setPtr) cmdPtr <= shifter;
      if (ctl.doWrite) begin
        regWrData <= shifter;
        if (cmdPtr == ONESHOT_CMD) begin
          oneShot <= 1'b1;
        end else if (cmdPtr >= ALIAS_FIRST && cmdPtr <= ALIAS_LAST) begin
          regWrEn <= 1'b1;
          regWrAddr <= cmdPtr - ALIAS_SHIFT;
        end else if (cmdPtr > RO_LAST) begin
          regWrEn <= 1'b1;
          regWrAddr <= cmdPtr;
        end
      end
    end
  end
endmodule

// File: rtl/smb_target.sv
module smb_target
  import smb_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h4C,
  parameter logic [6:0] ARA_ADDR = 7'h0C,
  parameter int TIMEOUT = 8750000,
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic alertActive,
  input  logic alertCfg,
  output logic araDone,
  output logic [7:0] regRdAddr,
  input  logic [7:0] regRdData,
  output logic regWrEn,
  output logic [7:0] regWrAddr,
  output logic [7:0] regWrData,
  output logic oneShot,
  output logic statusRd
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawLine, lineLvl, lineRise, lineFall;
  logic sclLvl, sdaLvl, timedOut, txBit;
  logic [BYTE_W-1:0] rxByte;
  dpCtl_t ctl;

  assign rawLine = {sdaIn, sclIn};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    smb_line_filter #(.FILT(FILT)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLine[g]),
      .lvl(lineLvl[g]), .rise(lineRise[g]), .fall(lineFall[g])
    );
  end

  assign sclLvl = lineLvl[0];
  assign sdaLvl = lineLvl[1];

  smb_ctrl #(.OWN_ADDR(OWN_ADDR), .ARA_ADDR(ARA_ADDR), .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclLvl(sclLvl), .sclRise(lineRise[0]), .sclFall(lineFall[0]),
    .sdaLvl(sdaLvl), .sdaRise(lineRise[1]), .sdaFall(lineFall[1]),
    .rxByte(rxByte), .txBit(txBit),
    .alertActive(alertActive), .alertCfg(alertCfg),
    .ctl(ctl), .sdaOe(sdaOe), .araDone(araDone), .timedOut(timedOut)
  );

  smb_dp #(.OWN_ADDR(OWN_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaLvl(sdaLvl),
    .regRdData(regRdData), .rxByte(rxByte), .txBit(txBit),
    .regRdAddr(regRdAddr), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .oneShot(oneShot), .statusRd(statusRd)
  );
endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk (
  input logic clk,
  input logic rstN,
  input logic sdaOe,
  input logic sclLvl,
  input logic timedOut,
  input logic regWrEn,
  input logic [7:0] regWrAddr,
  input logic oneShot,
  input logic statusRd,
  input logic araDone,
  input logic alertActive,
  input logic alertCfg
);
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN) regWrEn |=> !regWrEn); // R3
  AST_WR_FOLDED: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regWrAddr >= 8'h03) && (regWrAddr != 8'h0F) && !(regWrAddr >= 8'h09 && regWrAddr <= 8'h0E)); // R4
  AST_ONESHOT_EXCL: assert property (@(posedge clk) disable iff (!rstN) oneShot |-> !regWrEn); // R5
  AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rstN) statusRd |=> !statusRd); // R7
  AST_ARA_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN) araDone |-> alertActive && !alertCfg); // R8
  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rstN) timedOut |=> !sdaOe); // R10
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) && !$past(timedOut) |-> !sclLvl); // R12
endmodule

bind smb_target smb_target_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclLvl(sclLvl), .timedOut(timedOut),
  .regWrEn(regWrEn), .regWrAddr(regWrAddr), .oneShot(oneShot), .statusRd(statusRd),
  .araDone(araDone), .alertActive(alertActive), .alertCfg(alertCfg)
);

// File: tb/test_smb_target.sv
`timescale 1ns/1ps
module test_smb_target;
  localparam int Q = 7;
  localparam int TMO = 400;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclHost = 1'b1, sdaHost = 1'b1, otherPull = 1'b1;
  logic sdaOe, araDone, regWrEn, oneShot, statusRd;
  logic alertActive = 1'b0, alertCfg = 1'b0;
  logic [7:0] regRdAddr, regRdData, regWrAddr, regWrData;
  logic sdaLine;
  int checks = 0, errors = 0;
  int nWr = 0, nOs = 0, nSt = 0, nAra = 0, sdaGlitch = 0;
  logic [7:0] lastWrA = '0, lastWrD = '0;

  always #2 clk = ~clk;

  assign sdaLine = sdaHost & ~sdaOe & otherPull;
  assign regRdData = 8'(regRdAddr * 8'd37 + 8'd11);

  smb_target #(.TIMEOUT(TMO), .FILT(3)) i_smb_target (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .alertActive(alertActive), .alertCfg(alertCfg), .araDone(araDone),
    .regRdAddr(regRdAddr), .regRdData(regRdData), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .oneShot(oneShot), .statusRd(statusRd)
  );

  always @(negedge clk) begin
    if (regWrEn) begin nWr++; lastWrA = regWrAddr; lastWrD = regWrData; end
    if (oneShot) nOs++;
    if (statusRd) nSt++;
    if (araDone) nAra++;
  end

  function automatic logic [7:0] model(input logic [7:0] a);
    return 8'(a * 8'd37 + 8'd11);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(posedge clk); #1; endtask
  task automatic startC; sdaHost = 1; wq; sclHost = 1; wq; sdaHost = 0; wq; sclHost = 0; wq; endtask
  task automatic stopC; sdaHost = 0; wq; sclHost = 1; wq; sdaHost = 1; wq; wq; endtask
  task automatic sendBit(input logic b); sdaHost = b; wq; sclHost = 1; wq; wq; sclHost = 0; wq; endtask
  task automatic recvBit(output logic b);
    logic early;
    sdaHost = 1; wq; sclHost = 1; wq;
    early = sdaLine; b = sdaLine; wq;
    if (sdaLine != early) sdaGlitch++;
    sclHost = 0; wq;
  endtask
  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = !b;
  endtask
  task automatic readByte(input logic ackIt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); v[i] = b; end
    sendBit(!ackIt);
  endtask
  task automatic setPtr(input logic [7:0] p);
    logic a;
    startC; sendByte(8'h98, a); sendByte(p, a); stopC;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v, v2;
    int w0, s0, o0, r0;
    repeat (10) @(posedge clk);
    #1;
    chk(sdaOe == 0 && regWrEn == 0 && oneShot == 0 && statusRd == 0 && araDone == 0, "R13 reset", sdaOe, 0);
    rstN = 1;
    wq;

    // R2: pointer resets to 00h, address-only read
    startC; sendByte(8'h99, a); readByte(0, v); stopC;
    chk(a, "R1 own read ack", a, 1);
    chk(v == model(8'h00), "R2 reset pointer read", v, model(8'h00));

    // R1: sweep every address byte
    for (int b = 0; b < 256; b++) begin
      logic exp;
      exp = (b[7:1] == 7'h4C);
      startC; sendByte(8'(b), a);
      if (a && b[0]) readByte(0, v);
      stopC;
      chk(a == exp, "R1 address match", a, exp);
    end

    // R3 R4 R5: write sweep over commands 00h..1Fh
    for (int c = 0; c < 32; c++) begin
      logic [7:0] d;
      int expA;
      d = 8'(c) ^ 8'hA5;
      w0 = nWr; o0 = nOs;
      startC; sendByte(8'h98, a); sendByte(8'(c), a); sendByte(d, a); stopC;
      chk(a, "R3 data ack", a, 1);
      if (c == 15) begin
        chk(nOs == o0 + 1 && nWr == w0, "R5 one-shot write", nOs - o0, 1);
      end else if (c <= 8) begin
        chk(nWr == w0 && nOs == o0, "R4 read-only command ignored", nWr - w0, 0);
      end else begin
        expA = (c <= 14) ? c - 6 : c;
        chk(nWr == w0 + 1, "R3 one write strobe", nWr - w0, 1);
        chk(lastWrA == 8'(expA), "R4 folded write index", lastWrA, expA);
        chk(lastWrD == d, "R3 write data", lastWrD, d);
      end
    end

    // R3: second data byte not acked, no second strobe
    w0 = nWr;
    startC; sendByte(8'h98, a); sendByte(8'h19, a); sendByte(8'h55, a); sendByte(8'hAA, a); stopC;
    chk(!a, "R3 extra byte nack", a, 0);
    chk(nWr == w0 + 1 && lastWrD == 8'h55, "R3 single write", lastWrD, 8'h55);

    // R2 R5 R7: pointer-only write then address-only read
    for (int p = 0; p < 16; p++) begin
      logic [7:0] e;
      w0 = nWr; s0 = nSt;
      setPtr(8'(p));
      chk(nWr == w0, "R3 pointer-only write no strobe", nWr - w0, 0);
      startC; sendByte(8'h99, a); readByte(0, v); stopC;
      e = (p == 15) ? 8'h00 : model(8'(p));
      chk(v == e, (p == 15) ? "R5 one-shot reads zero" : "R2 pointer read", v, e);
      chk(nSt - s0 == ((p == 2) ? 1 : 0), "R7 status strobe", nSt - s0, (p == 2) ? 1 : 0);
    end

    // R6: repeated-start read, ACK then NACK
    startC; sendByte(8'h98, a); sendByte(8'h05, a); startC; sendByte(8'h99, a);
    readByte(1, v); readByte(0, v2);
    chk(v == model(8'h05) && v2 == model(8'h05), "R6 repeated start read", v2, model(8'h05));
    wq;
    chk(sdaOe == 0, "R6 released after nack", sdaOe, 0);
    stopC;

    // R7: strobe per loaded byte regardless of host ack
    s0 = nSt;
    setPtr(8'h02);
    startC; sendByte(8'h99, a); readByte(1, v); readByte(0, v2); stopC;
    chk(nSt - s0 == 2, "R7 strobe per byte", nSt - s0, 2);

    // R11: start partway through an address byte
    startC; sendBit(1); sendBit(0); sendBit(1); sendBit(0);
    startC; sendByte(8'h98, a); sendByte(8'h07, a); startC; sendByte(8'h99, a); readByte(0, v); stopC;
    chk(v == model(8'h07), "R11 restart mid address", v, model(8'h07));

    // R8: alert response
    alertActive = 1; alertCfg = 0; r0 = nAra;
    startC; sendByte(8'h19, a); chk(a, "R8 alert response ack", a, 1);
    readByte(0, v); stopC;
    chk(v == 8'h98, "R8 own address sent", v, 8'h98);
    chk(nAra == r0 + 1, "R8 done pulse", nAra - r0, 1);
    alertCfg = 1;
    startC; sendByte(8'h19, a); stopC;
    chk(!a, "R8 comparator mode no ack", a, 0);
    alertCfg = 0;

    // R9: arbitration loss on first bit
    r0 = nAra;
    startC; sendByte(8'h19, a);
    otherPull = 0; recvBit(v[7]); otherPull = 1;
    for (int i = 6; i >= 0; i--) recvBit(v[i]);
    sendBit(1); stopC;
    chk(v[6:0] == 7'h7F, "R9 stops driving after loss", v[6:0], 8'h7F);
    chk(nAra == r0, "R9 no done pulse", nAra - r0, 0);
    alertActive = 0;

    // R10: timeout while the target drives SDA low
    setPtr(8'h00);
    startC; sendByte(8'h99, a);
    repeat (20) @(posedge clk); #1;
    chk(sdaOe == 1, "R10 driving before timeout", sdaOe, 1);
    repeat (TMO + 30) @(posedge clk); #1;
    chk(sdaOe == 0, "R10 released after timeout", sdaOe, 0);
    stopC;
    startC; sendByte(8'h99, a); readByte(0, v); stopC;
    chk(a && v == model(8'h00), "R10 recovers after timeout", v, model(8'h00));

    chk(sdaGlitch == 0, "R12 SDA stable while SCL high", sdaGlitch, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule